// File: doc/BRIEF.md
# Input-Capture Timer with Overflow Flags

This block is an 8-bit free-running up-counter for a small controller. Its count enable comes from a free-running divider on the system clock (divide by 2, 32 or 64) or from a slow watch-clock tick divided by 4. A control byte chooses the divider and the counter-clear mode, and it enables the overflow interrupt. The same byte holds two overflow flags that are set together on every wrap.

A capture pin is synchronised and edge-detected on the system clock. A chosen edge, or both edges, can zero the counter. A separate selectable edge raises a one-cycle capture interrupt pulse. The flags are cleared by software in two steps. A read must first see a flag set. A later write of 0 to that flag then clears it. An overflow that occurs between the read and the write keeps the flag set.

Top module: `cap_timer`

## Requirements
- R1: After reset the mode read value, the counter, `ovfIrq` and `capIrq` are all 0.
- R2: Clock select (mode bits 1:0) 00 advances the counter once every 64 system cycles, 01 once every 32 and 10 once every 2. The divider runs freely from reset.
- R3: Clock select 11 advances the counter on every fourth cycle with `watchTick` high.
- R4: When a count step takes the counter from 0xFF to 0x00, both flags (mode bits 7 and 6) are set in the next cycle.
- R5: A flag is cleared only by a write with that bit 0 that follows a read which returned that bit as 1. Writing 1 has no effect. Writing 0 without such a read has no effect.
- R6: An overflow that occurs after the arming read and before the write cancels the arming, so the flag stays set.
- R7: Counter-clear select (mode bits 3:2) 00 never clears, 01 clears on a falling synchronised capture edge, 10 clears on a rising one and 11 clears on both.
- R8: When a clear and a count step coincide, the counter becomes 0x00 and no flag is set.
- R9: `capIrq` pulses for one cycle on a rising capture edge when mode bit 4 is 0, and on a falling one when it is 1. The pulse appears three clock edges after the pin changes.
- R10: `ovfIrq` is high exactly when mode bit 5 is 1 and at least one flag is set.
- R11: A mode read returns the flags in bits 7:6. Bits 5:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Mode register write strobe |
| rdEn | input | 1 | Mode register read strobe (arms flag clearing) |
| wrData | input | 8 | Write data for the mode register |
| watchTick | input | 1 | One-cycle tick from the slow watch clock |
| capIn | input | 1 | Asynchronous capture pin |
| modeRd | output | 8 | Mode register read value |
| count | output | 8 | Counter value |
| ovfIrq | output | 1 | Overflow interrupt request |
| capIrq | output | 1 | Capture edge interrupt pulse |

## Verification
A divider phase error shows up as a change in `count` one step early or late. The bench compares `count` on every cycle, so it sees this at the first step. A stale arming latch would let a later write of 0 clear a flag. `modeRd` and `ovfIrq` would then drop one cycle after that write even though no fresh read preceded it. A synchroniser or edge-detect fault moves the `capIrq` pulse off the third edge after the pin change, or moves the counter clear by one cycle. The check against a cycle-accurate model catches either one on that same edge.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef struct packed {
    logic cntEn;
    logic cntClr;
  } tmrStrobe_t;

  localparam logic [1:0] CKS_SLOW  = 2'b00;
  localparam logic [1:0] CKS_MID   = 2'b01;
  localparam logic [1:0] CKS_FAST  = 2'b10;
  localparam logic [1:0] CKS_WATCH = 2'b11;

  localparam logic [1:0] CLR_NONE = 2'b00;
  localparam logic [1:0] CLR_FALL = 2'b01;
  localparam logic [1:0] CLR_RISE = 2'b10;
  localparam logic [1:0] CLR_BOTH = 2'b11;
endpackage

// File: rtl/cap_timer_ctrl.sv
module cap_timer_ctrl
  import cap_timer_pkg::*;
#(
  parameter int PRE_W  = 6,
  parameter int WDIV_W = 2,
  parameter int NFLAG  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  input  logic       watchTick,
  input  logic       capIn,
  input  logic       wrap,
  output tmrStrobe_t strobe,
  output logic [7:0] modeRd,
  output logic       ovfIrq,
  output logic       capIrq
);
  localparam int CTL_W  = 8 - NFLAG;
  localparam int MID_HI = PRE_W - 2;

  logic [CTL_W-1:0]  ctl;
  logic [NFLAG-1:0]  flag;
  logic [NFLAG-1:0]  arm;
  logic [PRE_W-1:0]  preDiv;
  logic [WDIV_W-1:0] watchDiv;
  logic capS1, capS2, capPrev;
  logic capRise, capFall, tickEn, clrHit;

  wire [1:0] cksSel  = ctl[1:0];
  wire [1:0] cclrSel = ctl[3:2];
  wire       iedgeSel = ctl[4];
  wire       ovie     = ctl[5];

  // free-running dividers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preDiv   <= '0;
      watchDiv <= '0;
    end else begin
      preDiv <= preDiv + 1'b1;
      if (watchTick) watchDiv <= watchDiv + 1'b1;
    end
  end

  always_comb begin
    unique case (cksSel)
      CKS_SLOW:  tickEn = &preDiv;
      CKS_MID:   tickEn = &preDiv[MID_HI:0];
      CKS_FAST:  tickEn = preDiv[0];
      default:   tickEn = watchTick & (&watchDiv);
    endcase
  end

  // capture synchroniser and edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capS1   <= 1'b0;
      capS2   <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      capS1   <= capIn;
      capS2   <= capS1;
      capPrev <= capS2;
    end
  end

  assign capRise = capS2 & ~capPrev;
  assign capFall = ~capS2 & capPrev;

  always_comb begin
    unique case (cclrSel)
      CLR_FALL: clrHit = capFall;
      CLR_RISE: clrHit = capRise;
      CLR_BOTH: clrHit = capRise | capFall;
      default:  clrHit = 1'b0;
    endcase
  end

  assign strobe.cntEn  = tickEn;
  assign strobe.cntClr = clrHit;
  assign capIrq        = iedgeSel ? capFall : capRise;

  // control bits
  always_ff @(posedge clk) begin
    if (!rstN)     ctl <= '0;
    else if (wrEn) ctl <= wrData[CTL_W-1:0];
  end

  // overflow flags with read-then-write-zero clearing
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flag[i] <= 1'b0;
        arm[i]  <= 1'b0;
      end else begin
        if (wrap)
          flag[i] <= 1'b1;
        else if (wrEn && !wrData[CTL_W+i] && arm[i])
          flag[i] <= 1'b0;

        if (wrap || wrEn)
          arm[i] <= 1'b0;
        else if (rdEn && flag[i])
          arm[i] <= 1'b1;
      end
    end
  end

  assign modeRd = {flag, {CTL_W{1'b0}}};
  assign ovfIrq = ovie & (|flag);
endmodule

// File: rtl/cap_timer_dp.sv
module cap_timer_dp
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntEn)  cnt <= cnt + 1'b1;
  end

  assign wrap  = strobe.cntEn & ~strobe.cntClr & (&cnt);
  assign count = cnt;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [7:0]       wrData,
  input  logic             watchTick,
  input  logic             capIn,
  output logic [7:0]       modeRd,
  output logic [CNT_W-1:0] count,
  output logic             ovfIrq,
  output logic             capIrq
);
  tmrStrobe_t strobe;
  logic       wrap;

  cap_timer_ctrl #(.PRE_W(PRE_W), .WDIV_W(2), .NFLAG(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .watchTick(watchTick), .capIn(capIn), .wrap(wrap), .strobe(strobe),
    .modeRd(modeRd), .ovfIrq(ovfIrq), .capIrq(capIrq)
  );

  cap_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count), .wrap(wrap)
  );
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] modeRd,
  input logic [7:0] count,
  input logic       ovfIrq,
  input logic       capIrq
);
  // R4
  flag_set_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeRd[7]) |-> ($past(count) == 8'hFF && count == 8'h00));

  // R5
  flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modeRd[6]) |-> ($past(wrEn) && !$past(wrData[6])));

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> (modeRd[7] || modeRd[6]));

  // R11
  ctl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeRd[5:0] == 6'd0);

  // R9
  cap_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |=> !capIrq);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == $past(count) + 8'd1 || count == 8'd0));
endmodule

bind cap_timer cap_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .modeRd(modeRd),
  .count(count), .ovfIrq(ovfIrq), .capIrq(capIrq)
);

// File: tb/cap_timer_tb.sv
module cap_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, watchTick = 1'b0, capIn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] modeRd, count;
  logic ovfIrq, capIrq;
  int nChk = 0, nBad = 0;

  always #2 clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .watchTick(watchTick), .capIn(capIn), .modeRd(modeRd), .count(count),
    .ovfIrq(ovfIrq), .capIrq(capIrq)
  );

  // cycle model built from the requirements
  logic [5:0] mCtl, mPre;
  logic [1:0] mFlag, mArm, mW;
  logic [7:0] mCnt;
  logic mS1, mS2, mP, mTick, mClr, mRise, mFall, mWrap;

  function automatic logic tickOf(logic [1:0] sel, logic [5:0] pre, logic [1:0] w, logic wt);
    case (sel)
      2'b00: return pre == 6'd63;
      2'b01: return pre[4:0] == 5'd31;
      2'b10: return pre[0];
      default: return wt && w == 2'd3;
    endcase
  endfunction

  function automatic logic clrOf(logic [1:0] sel, logic r, logic f);
    return (sel == 2'b01 && f) || (sel == 2'b10 && r) || (sel == 2'b11 && (r || f));
  endfunction

  always_comb begin
    mRise = mS2 && !mP;
    mFall = !mS2 && mP;
    mTick = tickOf(mCtl[1:0], mPre, mW, watchTick);
    mClr  = clrOf(mCtl[3:2], mRise, mFall);
    mWrap = mTick && !mClr && mCnt == 8'hFF;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mCtl <= 0; mPre <= 0; mFlag <= 0; mArm <= 0; mW <= 0; mCnt <= 0;
      mS1 <= 0; mS2 <= 0; mP <= 0;
    end else begin
      mPre <= mPre + 1;
      if (watchTick) mW <= mW + 1;
      mS1 <= capIn; mS2 <= mS1; mP <= mS2;
      if (wrEn) mCtl <= wrData[5:0];
      if (mClr) mCnt <= 0; else if (mTick) mCnt <= mCnt + 1;
      for (int i = 0; i < 2; i++) begin
        if (mWrap) mFlag[i] <= 1;
        else if (wrEn && !wrData[6+i] && mArm[i]) mFlag[i] <= 0;
        if (mWrap || wrEn) mArm[i] <= 0;
        else if (rdEn && mFlag[i]) mArm[i] <= 1;
      end
    end
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cmpModel(string req);
    check(req, "count", count, mCnt);
    check(req, "modeRd", modeRd, {mFlag, 6'd0});
    check(req, "ovfIrq", {7'd0, ovfIrq}, {7'd0, mCtl[5] && (|mFlag)});
    check(req, "capIrq", {7'd0, capIrq}, {7'd0, mCtl[4] ? mFall : mRise});
  endtask

  task automatic writeMode(logic [7:0] d);
    wrEn = 1; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  // random phase: pCap = capture toggle percent, pWt = tick percent
  task automatic runPhase(string req, int n, int pCap, int pWt, int pRd, int pWr, logic [5:0] ctl);
    for (int k = 0; k < n; k++) begin
      cmpModel(req);
      capIn     = ($urandom_range(99) < pCap) ? ~capIn : capIn;
      watchTick = $urandom_range(99) < pWt;
      rdEn      = $urandom_range(99) < pRd;
      wrEn      = $urandom_range(99) < pWr;
      wrData    = {2'($urandom_range(3)), ctl};
      @(negedge clk);
    end
    rdEn = 0; wrEn = 0; watchTick = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1", "modeRd", modeRd, 8'h00);
    check("R1", "count", count, 8'h00);
    check("R1", "irqs", {6'd0, ovfIrq, capIrq}, 8'h00);

    // R2 prescaled rates
    for (int s = 0; s < 3; s++) begin
      writeMode({6'd0, 2'(s)});
      runPhase("R2", 3000, 0, 0, 0, 0, {4'd0, 2'(s)});
    end
    // R3 watch tick divide by 4
    writeMode(8'h03);
    runPhase("R3", 3000, 0, 50, 0, 0, 6'h03);

    // R4 wrap sets both flags; R5 writes without a read do nothing
    writeMode(8'h02);
    while (count != 8'hFF) @(negedge clk);
    while (count == 8'hFF) @(negedge clk);
    check("R4", "flags after wrap", modeRd, 8'hC0);
    check("R4", "count after wrap", count, 8'h00);
    writeMode(8'h02);
    check("R5", "write 0 without read", modeRd, 8'hC0);
    rdEn = 1; @(negedge clk); rdEn = 0;
    writeMode(8'hC2);
    check("R5", "write 1 after read", modeRd, 8'hC0);
    rdEn = 1; @(negedge clk); rdEn = 0;
    writeMode(8'h82);
    check("R5", "clear L only", modeRd, 8'h80);
    check("R11", "ctl bits read 0", {2'd0, modeRd[5:0]}, 8'h00);

    // R7 / R9 clear modes and capture edge select
    for (int c = 1; c < 4; c++)
      for (int e = 0; e < 2; e++) begin
        writeMode({3'd0, 1'(e), 2'(c), 2'b10});
        runPhase((e == 0) ? "R7" : "R9", 1500, 10, 0, 0, 0, {1'b0, 1'(e), 2'(c), 2'b10});
      end
    // R8 clear against count step
    writeMode(8'h0E);
    runPhase("R8", 2000, 40, 0, 0, 0, 6'h0E);
    // R5 / R6 / R10 read-write clearing under overflow traffic
    writeMode(8'h22);
    runPhase("R6", 8000, 0, 0, 3, 1, 6'h22);
    writeMode(8'h02);
    runPhase("R10", 2000, 0, 0, 5, 2, 6'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL R1 watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule